// File: doc/BRIEF.md
# Periodic Core Self-Test Sequencer

This block paces concurrent self-test across a group of identical processor cores. One core at a time is chosen in strict rotation. The block tells the operating system on that core that a test is coming, waits until software confirms the core has been emptied of work, and then opens a test window of programmable length. At the end of the window it reads a pass/fail indication from the core's test logic. A pass raises a completion interrupt. A fail raises a recovery request that the core-side logic must accept.

Software programs three counts, all in clock ticks. The first is the full test period for any one core. The second is the window length. The third is how long to wait for the acknowledgment. Starts on successive cores are spaced by the period divided by the core count. The window length is expected to be shorter than that spacing. If software never acknowledges, the core is skipped, a sticky flag records the miss, and the rotation moves on. Both interrupts are level outputs that stay high until software writes a clear bit for them.

The controller is a six-state machine. IDLE waits for a slot tick. ANNOUNCE sets the pending interrupt. WAIT_ACK waits for the software write, or leaves on timeout. TESTING runs the window. DONE raises the completion interrupt. RECOVER holds the recovery request. The transitions are:
- IDLE to ANNOUNCE on a slot tick.
- ANNOUNCE to WAIT_ACK unconditionally.
- WAIT_ACK to TESTING on an acknowledgment write.
- WAIT_ACK to IDLE on timeout.
- TESTING to DONE, or TESTING to RECOVER, at the last cycle of the window, depending on the result.
- DONE to IDLE unconditionally.
- RECOVER to IDLE when the recovery acknowledgment input is high.

Top module: `ost_seq_ctrl`

## Requirements
- R1: After reset the outputs are as follows: every per-core output is zero, `phase` is 0, `cur_core` is 0, and both sticky flags are clear. The block stays in IDLE until the enable register (address 6, bit 0) is set.
- R2: Cores are visited in the order 0, 1, …, N-1, and the order then wraps to 0. The rotation advances after a pass, after a recovery and after a timeout skip.
- R3: Each test opens with the selected core's bit in `sched_irq` rising. While the controller waits for software, `phase` reads 2. The phase codes are IDLE=0, ANNOUNCE=1, WAIT_ACK=2, TESTING=3, DONE=4, RECOVER=5.
- R4: A write to address 3 in WAIT_ACK starts the test. A write to address 3 in any other phase has no effect: a later announcement still waits in WAIT_ACK with `test_en` low.
- R5: The test window lasts exactly as many cycles as the latency register (address 1). During the window, `test_en` carries only the bit of the core under test.
- R6: When `core_fail` for the tested core is low at the last window cycle, that core's `done_irq` bit is set and `recover_req` stays zero.
- R7: When `core_fail` for the tested core is high at the last window cycle, the following happens:
  - `recover_req` carries that core's bit until `recover_ack` is sampled high.
  - `done_irq` stays zero.
  - `fail_flag` is set and `fail_core` records the core index.
- R8: When each test finishes within the slot, consecutive `sched_irq` rises are spaced by the period register (address 0) divided by N cycles.
- R9: If no acknowledgment arrives, WAIT_ACK lasts the timeout register (address 2) in cycles. The controller then returns to IDLE, sets `timeout_flag` and advances the rotation.
- R10: A write to address 4 clears interrupts: bit i clears `sched_irq[i]` and bit N+i clears `done_irq[i]`. A write to address 5 clears sticky flags: bit 0 clears `fail_flag` and bit 1 clears `timeout_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| core_fail | input | N | Per-core test result, high means fail |
| recover_ack | input | 1 | Core-side acceptance of the recovery request |
| sched_irq | output | N | Level test-pending interrupt per core |
| done_irq | output | N | Level test-complete interrupt per core |
| test_en | output | N | Test window active per core |
| recover_req | output | N | Recovery request per core |
| cur_core | output | log2 N | Index of the selected core |
| phase | output | 3 | Controller phase code |
| fail_flag | output | 1 | Sticky failed-test flag |
| fail_core | output | log2 N | Index of the last failing core |
| timeout_flag | output | 1 | Sticky acknowledgment-timeout flag |

## Verification
The bench goes after three kinds of fault.

The first is an acknowledgment written while no test is pending. A design that latched it would skip the wait and start testing a core that software has not prepared. The bench therefore checks that a later announcement still waits.

The second is the fail branch. A faulty design might raise the completion interrupt as well as, or instead of, the recovery request. It might also drop the request before the core side accepts it.

The third is the timeout path and the wrap of the rotation. Here a wrong design would hang in WAIT_ACK, retest the same core, or miscount the window or the acknowledgment wait by one cycle.

// File: rtl/ost_pkg.sv
package ost_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ANNOUNCE = 3'd1,
        ST_WAIT_ACK = 3'd2,
        ST_TESTING  = 3'd3,
        ST_DONE     = 3'd4,
        ST_RECOVER  = 3'd5
    } ost_state_e;

    localparam logic [2:0] A_PERIOD  = 3'd0;
    localparam logic [2:0] A_LATENCY = 3'd1;
    localparam logic [2:0] A_TIMEOUT = 3'd2;
    localparam logic [2:0] A_ACK     = 3'd3;
    localparam logic [2:0] A_IRQCLR  = 3'd4;
    localparam logic [2:0] A_FLAGCLR = 3'd5;
    localparam logic [2:0] A_ENABLE  = 3'd6;
endpackage

// File: rtl/ost_slot_timer.sv
module ost_slot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] spacing,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = en && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (cnt_q + 1'b1 >= spacing) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ost_irq_bank.sv
module ost_irq_bank #(
    parameter int NUM   = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [NUM-1:0]   clr,
    output logic [NUM-1:0]   level
);
    for (genvar i = 0; i < NUM; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                level[i] <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(i))) begin
                level[i] <= 1'b1;
            end else if (clr[i]) begin
                level[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ost_seq_ctrl.sv
module ost_seq_ctrl
    import ost_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [2:0]                   cfg_addr,
    input  logic [31:0]                  cfg_wdata,
    input  logic [NUM_CORES-1:0]         core_fail,
    input  logic                         recover_ack,
    output logic [NUM_CORES-1:0]         sched_irq,
    output logic [NUM_CORES-1:0]         done_irq,
    output logic [NUM_CORES-1:0]         test_en,
    output logic [NUM_CORES-1:0]         recover_req,
    output logic [$clog2(NUM_CORES)-1:0] cur_core,
    output logic [2:0]                   phase,
    output logic                         fail_flag,
    output logic [$clog2(NUM_CORES)-1:0] fail_core,
    output logic                         timeout_flag
);
    localparam int IDX_W = $clog2(NUM_CORES);

    ost_state_e state_q, state_d;
    logic [CNT_W-1:0] period_q, lat_q, tmo_q;
    logic [CNT_W-1:0] wait_cnt_q, win_cnt_q;
    logic             en_q;
    logic [IDX_W-1:0] cur_q, cur_inc;
    logic             tick, ack_hit, tmo_evt, win_last, advance;
    logic [NUM_CORES-1:0] sched_clr, done_clr;

    assign ack_hit  = cfg_we && (cfg_addr == A_ACK);
    assign tmo_evt  = (state_q == ST_WAIT_ACK) && !ack_hit && (wait_cnt_q + 1'b1 >= tmo_q);
    assign win_last = (state_q == ST_TESTING) && (win_cnt_q + 1'b1 >= lat_q);
    assign advance  = (state_q == ST_DONE) || tmo_evt ||
                      ((state_q == ST_RECOVER) && recover_ack);
    assign cur_inc  = (cur_q == IDX_W'(NUM_CORES - 1)) ? '0 : cur_q + 1'b1;
    assign sched_clr = (cfg_we && cfg_addr == A_IRQCLR) ? cfg_wdata[NUM_CORES-1:0] : '0;
    assign done_clr  = (cfg_we && cfg_addr == A_IRQCLR) ? cfg_wdata[2*NUM_CORES-1:NUM_CORES] : '0;

    ost_slot_timer #(.CNT_W(CNT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .spacing(period_q >> IDX_W), .tick(tick)
    );

    ost_irq_bank #(.NUM(NUM_CORES), .IDX_W(IDX_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .set_en(state_q == ST_ANNOUNCE),
        .set_idx(cur_q), .clr(sched_clr), .level(sched_irq)
    );

    ost_irq_bank #(.NUM(NUM_CORES), .IDX_W(IDX_W)) u_done (
        .clk(clk), .rst_n(rst_n), .set_en(state_q == ST_DONE),
        .set_idx(cur_q), .clr(done_clr), .level(done_irq)
    );

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= CNT_W'(1024);
            lat_q    <= CNT_W'(16);
            tmo_q    <= CNT_W'(64);
            en_q     <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                A_PERIOD:  period_q <= cfg_wdata[CNT_W-1:0];
                A_LATENCY: lat_q    <= cfg_wdata[CNT_W-1:0];
                A_TIMEOUT: tmo_q    <= cfg_wdata[CNT_W-1:0];
                A_ENABLE:  en_q     <= cfg_wdata[0];
                default:   ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (tick) state_d = ST_ANNOUNCE;
            ST_ANNOUNCE: state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (ack_hit)      state_d = ST_TESTING;
                else if (tmo_evt) state_d = ST_IDLE;
            end
            ST_TESTING:  if (win_last) state_d = core_fail[cur_q] ? ST_RECOVER : ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            ST_RECOVER:  if (recover_ack) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cur_q        <= '0;
            wait_cnt_q   <= '0;
            win_cnt_q    <= '0;
            fail_flag    <= 1'b0;
            fail_core    <= '0;
            timeout_flag <= 1'b0;
        end else begin
            state_q    <= state_d;
            wait_cnt_q <= (state_q == ST_WAIT_ACK) ? wait_cnt_q + 1'b1 : '0;
            win_cnt_q  <= (state_q == ST_TESTING) ? win_cnt_q + 1'b1 : '0;
            if (advance) cur_q <= cur_inc;
            if (win_last && core_fail[cur_q]) begin
                fail_flag <= 1'b1;
                fail_core <= cur_q;
            end else if (cfg_we && cfg_addr == A_FLAGCLR && cfg_wdata[0]) begin
                fail_flag <= 1'b0;
            end
            if (tmo_evt) begin
                timeout_flag <= 1'b1;
            end else if (cfg_we && cfg_addr == A_FLAGCLR && cfg_wdata[1]) begin
                timeout_flag <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        test_en     = '0;
        recover_req = '0;
        if (state_q == ST_TESTING) test_en[cur_q]     = 1'b1;
        if (state_q == ST_RECOVER) recover_req[cur_q] = 1'b1;
        cur_core = cur_q;
        phase    = state_q;
    end

    // R5
    test_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(test_en));

    // R4
    ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ACK && !ack_hit) |=> (state_q != ST_TESTING));

    // R7
    recov_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|recover_req) |-> (test_en == '0) && $onehot(recover_req));

    // R2
    rotation_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_core != $past(cur_core)) |->
        (cur_core == (($past(cur_core) == IDX_W'(NUM_CORES - 1)) ? '0 : $past(cur_core) + 1'b1)));

    // R5
    window_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TESTING) |=> (state_q != ST_TESTING) || (win_cnt_q != '0));
endmodule

// File: tb/ost_seq_ctrl_test.sv
module ost_seq_ctrl_test;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [N-1:0] core_fail = '0;
    logic recover_ack = 1'b0;
    logic [N-1:0] sched_irq, done_irq, test_en, recover_req;
    logic [1:0] cur_core, fail_core;
    logic [2:0] phase;
    logic fail_flag, timeout_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int exp_q[$];
    int rise_t[$];
    logic [N-1:0] prev_irq = '0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ost_seq_ctrl #(.NUM_CORES(N), .CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .core_fail(core_fail), .recover_ack(recover_ack),
        .sched_irq(sched_irq), .done_irq(done_irq), .test_en(test_en),
        .recover_req(recover_req), .cur_core(cur_core), .phase(phase),
        .fail_flag(fail_flag), .fail_core(fail_core), .timeout_flag(timeout_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare every announcement against the expected core order
    always @(negedge clk) begin
        if (rst_n) begin
            logic [N-1:0] rise;
            rise = sched_irq & ~prev_irq;
            prev_irq = sched_irq;
            if (rise != '0) begin
                int idx;
                idx = 0;
                for (int i = 0; i < N; i++) if (rise[i]) idx = i;
                rise_t.push_back(cyc);
                chk($onehot(rise), "R3 single announce", int'(rise), 1 << idx);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected announce", idx, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(idx == e, "R2 rotation order", idx, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_sched(input int c);
        int n;
        n = 0;
        while (!sched_irq[c] && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(sched_irq[c], "R3 announce seen", int'(sched_irq), 1 << c);
    endtask

    task automatic run_pass(input int c);
        int n;
        wr(3'd3, 32'd1);
        n = 0;
        while (test_en == N'(1 << c) && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(n == 5, "R5 window length", n, 5);
        repeat (2) @(negedge clk);
        chk(done_irq == N'(1 << c), "R6 done irq", int'(done_irq), 1 << c);
        chk(recover_req == '0, "R6 no recovery", int'(recover_req), 0);
        wr(3'd4, (32'd1 << c) | (32'd1 << (N + c)));
        chk(sched_irq == '0 && done_irq == '0, "R10 irq clear",
            int'({sched_irq, done_irq}), 0);
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sched_irq == '0 && done_irq == '0 && test_en == '0 && recover_req == '0,
            "R1 reset outputs", int'({sched_irq, done_irq, test_en, recover_req}), 0);
        chk(phase == 3'd0 && cur_core == 2'd0, "R1 reset phase", int'(phase), 0);
        chk(!fail_flag && !timeout_flag, "R1 reset flags", int'({fail_flag, timeout_flag}), 0);
        repeat (20) @(negedge clk);
        chk(phase == 3'd0, "R1 idle while disabled", int'(phase), 0);

        wr(3'd0, 32'd64);
        wr(3'd1, 32'd5);
        wr(3'd2, 32'd8);
        exp_q = '{0, 1, 2, 3, 0};
        wr(3'd6, 32'd1);

        // core 0 and 1 pass
        wait_sched(0);
        chk(phase == 3'd2, "R3 wait-ack phase", int'(phase), 2);
        run_pass(0);
        wait_sched(1);
        run_pass(1);
        chk(rise_t.size() >= 2 && rise_t[1] - rise_t[0] == 16, "R8 start spacing",
            rise_t.size() >= 2 ? rise_t[1] - rise_t[0] : -1, 16);

        // stray acknowledgment while idle
        chk(phase == 3'd0, "R4 idle before stray ack", int'(phase), 0);
        wr(3'd3, 32'd1);
        chk(test_en == '0, "R4 stray ack no test", int'(test_en), 0);

        // core 2 fails
        core_fail = 4'b0100;
        wait_sched(2);
        repeat (3) @(negedge clk);
        chk(phase == 3'd2 && test_en == '0, "R4 stray ack ignored", int'(phase), 2);
        wr(3'd3, 32'd1);
        for (int i = 0; i < 20 && phase != 3'd5; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(recover_req == 4'b0100, "R7 recovery held", int'(recover_req), 4);
        chk(done_irq == '0, "R7 no done irq", int'(done_irq), 0);
        chk(fail_flag && fail_core == 2'd2, "R7 fail flag core", int'(fail_core), 2);
        @(negedge clk) recover_ack = 1'b1;
        @(negedge clk) recover_ack = 1'b0;
        chk(recover_req == '0 && phase == 3'd0, "R7 recovery released",
            int'(recover_req), 0);
        core_fail = '0;
        wr(3'd4, 32'd4);

        // core 3 never acknowledged
        wait_sched(3);
        begin
            int n;
            n = 0;
            while (phase == 3'd2 && n < 50) begin
                n++;
                @(negedge clk);
            end
            chk(n == 8, "R9 timeout length", n, 8);
        end
        chk(timeout_flag, "R9 timeout flag", int'(timeout_flag), 1);
        chk(cur_core == 2'd0 && phase == 3'd0, "R9 skip advances", int'(cur_core), 0);
        chk(done_irq == '0 && recover_req == '0, "R9 no result", int'(done_irq), 0);
        wr(3'd4, 32'd8);
        wr(3'd5, 32'd3);
        chk(!fail_flag && !timeout_flag, "R10 flag clear", int'({fail_flag, timeout_flag}), 0);

        // wrap to core 0
        wait_sched(0);
        wr(3'd6, 32'd0);
        run_pass(0);
        chk(exp_q.size() == 0, "R2 all announcements seen", exp_q.size(), 0);

        finished = 1'b1;
        report();
    end
endmodule